// File: doc/BRIEF.md
# Peripheral Bus Protocol Bridge

This block sits between a 64-bit system bus and a 32-bit peripheral bus. It accepts one system transfer at a time and runs it as one or two peripheral cycles. Each peripheral cycle has a setup phase followed by an access phase that lasts until the addressed peripheral signals ready.

The bridge owns a 1 MB address window, which is cut into fixed 16 KB slots. Bits [19:14] of the address pick a slot, and each slot has its own select line. Data transfers of byte, halfword and word size travel in the 32-bit lane picked by address bit 2. They must not straddle a 32-bit boundary, and the bridge does not check for this.

A 64-bit instruction fetch is the only transfer that gets resized. It becomes two back-to-back 32-bit reads, the lower word first, and the two words are joined into one 64-bit reply. Peripheral errors, unmatched addresses and unsupported sizes all come back as an error on the system side.

Top module: `pbr_top`

## Requirements
- R1: A request is taken when `sysValid` and `sysAccept` are both high. `sysAccept` then stays low until the cycle after the single-cycle `sysDone` pulse that ends the transfer.
- R2: Each peripheral cycle begins with one setup cycle, in which a select is high and `perEnable` is low. It is followed by access cycles with `perEnable` high and the same select held, until `perReady` is seen.
- R3: An address whose bits [31:20] equal the window base is in the window. Its bits [19:14] give the slot number n, and only `perSel[n]` is driven.
- R4: An address outside the window, or one whose slot number is at least `NUM_SLOTS`, drives no select and starts no access phase. The transfer ends with `sysErr` high.
- R5: `sysSize` is coded 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. Byte enables are 4'b0001 shifted left by addr[1:0] for a byte, 4'b0011 shifted left by addr[1:0] (cut to 4 bits) for a halfword, and 4'b1111 for a word or a fetch.
- R6: A write takes `sysWdata[63:32]` when addr[2] is 1 and `sysWdata[31:0]` otherwise. `perWrite` is high for the access, and `perAddr` equals the system address.
- R7: A read places the peripheral word in the lane picked by addr[2] and puts zeros in the other lane.
- R8: A fetch (`sysInstr` = 1 with size 3) reads address A with bits [1:0] cleared, then A+4, with `perWrite` low. It returns `{second word, first word}` with a single `sysDone`.
- R9: A peripheral error on either half of a fetch ends the transfer with `sysErr`. An error on the first half skips the second half.
- R10: A fetch whose address is not 8-byte aligned is forwarded as in R8 and raises no error of its own.
- R11: A size-3 transfer with `sysInstr` low starts no peripheral cycle and ends with `sysErr`.
- R12: A peripheral error on a single access ends the transfer with `sysErr`.
- R13: After reset, `sysAccept` is high and `sysDone`, `perEnable` and every select are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sysValid | input | 1 | System request valid |
| sysAccept | output | 1 | Bridge idle, request can be taken |
| sysAddr | input | 32 | System byte address |
| sysWrite | input | 1 | 1 = write |
| sysSize | input | 2 | Transfer size code |
| sysInstr | input | 1 | Instruction fetch flag |
| sysWdata | input | 64 | System write data |
| sysDone | output | 1 | Transfer complete pulse |
| sysErr | output | 1 | Error response, valid with sysDone |
| sysRdata | output | 64 | Read data, valid with sysDone |
| perSel | output | NUM_SLOTS | One-hot slot selects |
| perAddr | output | 32 | Peripheral address |
| perWrite | output | 1 | Peripheral write |
| perByteEn | output | 4 | Peripheral byte enables |
| perWdata | output | 32 | Peripheral write data |
| perEnable | output | 1 | Access phase marker |
| perReady | input | 1 | Peripheral ready |
| perRdata | input | 32 | Peripheral read data |
| perErr | input | 1 | Peripheral error, valid with perReady |

## Verification
In a fetch, the peripheral error and the hand-over to the upper half can land in the same cycle. This happens when the ready that ends the first read also carries an error. The bench provokes it by marking the lower-half address of a fetch as failing. It then checks that no second access phase follows and that `sysDone` arrives with `sysErr` high. Errors on the upper half, and upper halves that fall outside the slot range, are judged the same way: exactly as many access phases as expected, then an error reply.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  localparam int SLOT_W = 6;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } xferSize_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_RESP   = 2'd3
  } bridgeState_t;

  typedef struct packed {
    logic load;    // capture a new system request
    logic upper;   // second half of a split fetch
    logic drive;   // peripheral cycle in progress on a matched slot
    logic capLo;   // capture first peripheral word
    logic capHi;   // capture second peripheral word
    logic setErr;  // flag error for the system response
  } ctlStrobes_t;
endpackage

// File: rtl/pbr_ctrl.sv
module pbr_ctrl
  import pbr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sysValid,
  input  logic        reqOk,
  input  logic        isSplit,
  input  logic        perReady,
  input  logic        perErr,
  output logic        sysAccept,
  output logic        sysDone,
  output logic        perEnable,
  output ctlStrobes_t strobe
);
  bridgeState_t st, stNext;
  logic upper, upperNext;

  always_comb begin
    stNext       = st;
    upperNext    = upper;
    strobe       = '0;
    strobe.upper = upper;
    strobe.drive = ((st == ST_SETUP) || (st == ST_ACCESS)) && reqOk;
    case (st)
      ST_IDLE: begin
        if (sysValid) begin
          strobe.load = 1'b1;
          upperNext   = 1'b0;
          stNext      = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (!reqOk) begin
          strobe.setErr = 1'b1;
          stNext        = ST_RESP;
        end else begin
          stNext = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (perReady) begin
          if (perErr) begin
            strobe.setErr = 1'b1;
            stNext        = ST_RESP;
          end else if (upper) begin
            strobe.capHi = 1'b1;
            stNext       = ST_RESP;
          end else begin
            strobe.capLo = 1'b1;
            if (isSplit) begin
              upperNext = 1'b1;
              stNext    = ST_SETUP;
            end else begin
              stNext = ST_RESP;
            end
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      upper <= 1'b0;
    end else begin
      st    <= stNext;
      upper <= upperNext;
    end
  end

  assign sysAccept = (st == ST_IDLE);
  assign sysDone   = (st == ST_RESP);
  assign perEnable = (st == ST_ACCESS);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    sysDone |=> !sysDone);
  assert_accept_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sysValid && sysAccept) |=> !sysAccept);
  assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (perEnable && !perReady) |=> perEnable);
  assert_enable_after_setup_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(perEnable) |-> $past(strobe.drive));
endmodule

// File: rtl/pbr_dpath.sv
module pbr_dpath
  import pbr_pkg::*;
#(
  parameter int          NUM_SLOTS = 20,
  parameter logic [31:0] WIN_BASE  = 32'hC000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobe,
  input  logic [31:0]          sysAddr,
  input  logic                 sysWrite,
  input  logic [1:0]           sysSize,
  input  logic                 sysInstr,
  input  logic [63:0]          sysWdata,
  input  logic [31:0]          perRdata,
  output logic                 reqOk,
  output logic                 isSplit,
  output logic                 sysErr,
  output logic [63:0]          sysRdata,
  output logic [NUM_SLOTS-1:0] perSel,
  output logic [31:0]          perAddr,
  output logic                 perWrite,
  output logic [3:0]           perByteEn,
  output logic [31:0]          perWdata
);
  localparam int WIN_LSB = 20;
  localparam int SLOT_LSB = WIN_LSB - SLOT_W;

  logic [31:0] rAddr, rWdata, rdLo, rdHi;
  logic        rWrite, rInstr, errFlag;
  xferSize_t   rSize;
  logic [31:0] baseAddr, curAddr;
  logic [SLOT_W-1:0] slotIdx;
  logic        inWin, slotHit, badSize;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rAddr   <= '0;
      rWdata  <= '0;
      rWrite  <= 1'b0;
      rInstr  <= 1'b0;
      rSize   <= SZ_BYTE;
      rdLo    <= '0;
      rdHi    <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.load) begin
        rAddr   <= sysAddr;
        rWrite  <= sysWrite;
        rInstr  <= sysInstr;
        rSize   <= xferSize_t'(sysSize);
        rWdata  <= sysAddr[2] ? sysWdata[63:32] : sysWdata[31:0];
        rdLo    <= '0;
        rdHi    <= '0;
        errFlag <= 1'b0;
      end
      if (strobe.capLo)  rdLo    <= perRdata;
      if (strobe.capHi)  rdHi    <= perRdata;
      if (strobe.setErr) errFlag <= 1'b1;
    end
  end

  assign isSplit  = rInstr && (rSize == SZ_DWORD);
  assign badSize  = !rInstr && (rSize == SZ_DWORD);
  assign baseAddr = {rAddr[31:2], 2'b00};
  assign curAddr  = isSplit ? (strobe.upper ? baseAddr + 32'd4 : baseAddr) : rAddr;

  assign inWin   = (curAddr[31:WIN_LSB] == WIN_BASE[31:WIN_LSB]);
  assign slotIdx = curAddr[WIN_LSB-1:SLOT_LSB];
  assign slotHit = inWin && ({1'b0, slotIdx} < (SLOT_W+1)'(NUM_SLOTS));
  assign reqOk   = slotHit && !badSize;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSel
    assign perSel[i] = strobe.drive && (slotIdx == SLOT_W'(i));
  end

  always_comb begin
    if (isSplit) perByteEn = 4'b1111;
    else begin
      case (rSize)
        SZ_BYTE: perByteEn = 4'b0001 << rAddr[1:0];
        SZ_HALF: perByteEn = 4'b0011 << rAddr[1:0];
        default: perByteEn = 4'b1111;
      endcase
    end
  end

  assign perAddr  = curAddr;
  assign perWrite = rWrite && !isSplit;
  assign perWdata = rWdata;
  assign sysErr   = errFlag;
  assign sysRdata = isSplit ? {rdHi, rdLo}
                  : (rAddr[2] ? {rdLo, 32'h0} : {32'h0, rdLo});

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(perSel));
  assert_upper_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.upper) |-> (perAddr == $past(perAddr) + 32'd4));
  assert_sel_has_lanes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (perSel != '0) |-> (perByteEn != 4'b0000));
endmodule

// File: rtl/pbr_top.sv
module pbr_top
  import pbr_pkg::*;
#(
  parameter int          NUM_SLOTS = 20,
  parameter logic [31:0] WIN_BASE  = 32'hC000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sysValid,
  output logic                 sysAccept,
  input  logic [31:0]          sysAddr,
  input  logic                 sysWrite,
  input  logic [1:0]           sysSize,
  input  logic                 sysInstr,
  input  logic [63:0]          sysWdata,
  output logic                 sysDone,
  output logic                 sysErr,
  output logic [63:0]          sysRdata,
  output logic [NUM_SLOTS-1:0] perSel,
  output logic [31:0]          perAddr,
  output logic                 perWrite,
  output logic [3:0]           perByteEn,
  output logic [31:0]          perWdata,
  output logic                 perEnable,
  input  logic                 perReady,
  input  logic [31:0]          perRdata,
  input  logic                 perErr
);
  ctlStrobes_t strobe;
  logic reqOk, isSplit;

  pbr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sysValid(sysValid), .reqOk(reqOk),
    .isSplit(isSplit), .perReady(perReady), .perErr(perErr),
    .sysAccept(sysAccept), .sysDone(sysDone), .perEnable(perEnable),
    .strobe(strobe)
  );

  pbr_dpath #(.NUM_SLOTS(NUM_SLOTS), .WIN_BASE(WIN_BASE)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sysAddr(sysAddr),
    .sysWrite(sysWrite), .sysSize(sysSize), .sysInstr(sysInstr),
    .sysWdata(sysWdata), .perRdata(perRdata), .reqOk(reqOk),
    .isSplit(isSplit), .sysErr(sysErr), .sysRdata(sysRdata),
    .perSel(perSel), .perAddr(perAddr), .perWrite(perWrite),
    .perByteEn(perByteEn), .perWdata(perWdata)
  );

  assert_enable_selected_R4: assert property (@(posedge clk) disable iff (!rstN)
    perEnable |-> (perSel != '0));
  assert_sel_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (perEnable && $past(perEnable)) |-> $stable(perSel));
endmodule

// File: tb/pbr_top_test.sv
module pbr_top_test;
  localparam int          NS   = 20;
  localparam logic [31:0] BASE = 32'hC000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic sysValid = 0, sysWrite = 0, sysInstr = 0;
  logic [31:0] sysAddr = '0;
  logic [1:0] sysSize = '0;
  logic [63:0] sysWdata = '0;
  logic sysAccept, sysDone, sysErr, perWrite, perEnable, perReady, perErr;
  logic [63:0] sysRdata;
  logic [NS-1:0] perSel;
  logic [31:0] perAddr, perWdata, perRdata;
  logic [3:0] perByteEn;

  int vectors = 0, errors = 0, cycles = 0, waitCycles = 0, waitCnt = 0;
  logic [31:0] errAddr = 32'hFFFF_FFFF;

  pbr_top #(.NUM_SLOTS(NS), .WIN_BASE(BASE)) uut (
    .clk(clk), .rstN(rstN), .sysValid(sysValid), .sysAccept(sysAccept),
    .sysAddr(sysAddr), .sysWrite(sysWrite), .sysSize(sysSize),
    .sysInstr(sysInstr), .sysWdata(sysWdata), .sysDone(sysDone),
    .sysErr(sysErr), .sysRdata(sysRdata), .perSel(perSel),
    .perAddr(perAddr), .perWrite(perWrite), .perByteEn(perByteEn),
    .perWdata(perWdata), .perEnable(perEnable), .perReady(perReady),
    .perRdata(perRdata), .perErr(perErr)
  );

  // peripheral model
  function automatic logic [31:0] pdata(logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction
  assign perReady = perEnable && (waitCnt == waitCycles);
  assign perRdata = pdata(perAddr);
  assign perErr   = perReady && (perAddr == errAddr);
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!perEnable || perReady) waitCnt <= 0;
    else waitCnt <= waitCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit inSlots(logic [31:0] a);
    return (a[31:20] == BASE[31:20]) && (int'(a[19:14]) < NS);
  endfunction

  task automatic xfer(input logic [31:0] addr, input bit wr, input logic [1:0] size,
                      input bit instr, input logic [63:0] wdata, input int waits,
                      input string req);
    logic [31:0] expA[2];
    logic [31:0] a0, a1, expWd;
    logic [3:0] expBe;
    logic [63:0] expRd;
    int expN = 0, seen = 0;
    bit expErr = 0, split, done = 0;
    split = instr && (size == 2'd3);
    waitCycles = waits;
    a0 = {addr[31:2], 2'b00};
    a1 = a0 + 32'd4;
    if (size == 2'd3 && !instr) expErr = 1;
    else if (split) begin
      if (!inSlots(a0)) expErr = 1;
      else begin
        expA[0] = a0; expN = 1;
        if (a0 == errAddr) expErr = 1;
        else if (!inSlots(a1)) expErr = 1;
        else begin
          expA[1] = a1; expN = 2;
          if (a1 == errAddr) expErr = 1;
        end
      end
    end else begin
      if (!inSlots(addr)) expErr = 1;
      else begin
        expA[0] = addr; expN = 1;
        if (addr == errAddr) expErr = 1;
      end
    end
    case (size)
      2'd0: expBe = 4'(4'b0001 << addr[1:0]);
      2'd1: expBe = 4'(4'b0011 << addr[1:0]);
      default: expBe = 4'hF;
    endcase
    expWd = addr[2] ? wdata[63:32] : wdata[31:0];
    expRd = split ? {pdata(a1), pdata(a0)}
          : (addr[2] ? {pdata(addr), 32'h0} : {32'h0, pdata(addr)});

    @(negedge clk);
    sysValid = 1; sysAddr = addr; sysWrite = wr; sysSize = size;
    sysInstr = instr; sysWdata = wdata;
    @(negedge clk);
    sysValid = 0;
    chk(sysAccept == 1'b0, {req, " R1 busy after accept"}, 64'(sysAccept), 64'd0);
    if (expN > 0) begin
      chk(perEnable == 1'b0 && perSel == NS'(1) << expA[0][19:14],
          {req, " R2 setup phase"}, 64'(perSel), 64'(NS'(1) << expA[0][19:14]));
    end
    for (int c = 0; c < 60 && !done; c++) begin
      if (c > 0) @(negedge clk);
      chk(!perEnable || perSel != '0, {req, " R4 access without select"},
          64'(perSel), 64'd1);
      if (perEnable && perReady) begin
        if (seen < expN) begin
          chk(perAddr == expA[seen], {req, " R8 address"}, 64'(perAddr), 64'(expA[seen]));
          chk(perSel == NS'(1) << expA[seen][19:14], {req, " R3 select"},
              64'(perSel), 64'(NS'(1) << expA[seen][19:14]));
          chk(perByteEn == expBe, {req, " R5 byte enables"}, 64'(perByteEn), 64'(expBe));
          chk(perWrite == (wr && !split), {req, " R6 write flag"}, 64'(perWrite),
              64'(wr && !split));
          if (wr && !split)
            chk(perWdata == expWd, {req, " R6 write lane"}, 64'(perWdata), 64'(expWd));
        end
        seen++;
      end
      if (sysDone) begin
        done = 1;
        chk(seen == expN, {req, " R9 access count"}, 64'(seen), 64'(expN));
        chk(sysErr == expErr, {req, " R12 error flag"}, 64'(sysErr), 64'(expErr));
        if (!expErr && !wr)
          chk(sysRdata == expRd, {req, " R7 read data"}, sysRdata, expRd);
      end
    end
    chk(done, {req, " R1 completion"}, 64'(done), 64'd1);
    @(negedge clk);
    chk(sysAccept && !sysDone, {req, " R1 idle after done"}, 64'({sysAccept, sysDone}),
        64'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(sysAccept && !sysDone && !perEnable && perSel == '0, "R13 reset",
        64'({sysAccept, sysDone, perEnable}), 64'b100);
    xfer(BASE | (32'd3 << 14) | 32'h14, 1, 2'd2, 0, 64'h1111_2222_3333_4444, 0, "R6 word wr");
    xfer(BASE | 32'h23, 0, 2'd0, 0, '0, 2, "R5 byte rd");
    xfer(BASE | (32'd7 << 14) | 32'h6, 0, 2'd1, 0, '0, 1, "R7 half rd hi");
    xfer(BASE | 32'h3, 1, 2'd1, 0, 64'hAAAA_BBBB_CCCC_DDDD, 0, "R5 half cut");
    xfer(BASE | (32'd5 << 14) | 32'h100, 0, 2'd3, 1, '0, 1, "R8 fetch");
    xfer(BASE | (32'd2 << 14) | 32'h1A3, 0, 2'd3, 1, '0, 0, "R10 misaligned");
    errAddr = BASE | (32'd4 << 14) | 32'h40;
    xfer(BASE | (32'd4 << 14) | 32'h40, 0, 2'd3, 1, '0, 0, "R9 err low half");
    errAddr = BASE | (32'd4 << 14) | 32'h84;
    xfer(BASE | (32'd4 << 14) | 32'h80, 0, 2'd3, 1, '0, 2, "R9 err high half");
    errAddr = BASE | (32'd1 << 14) | 32'h8;
    xfer(BASE | (32'd1 << 14) | 32'h8, 1, 2'd2, 0, 64'h0, 1, "R12 single err");
    errAddr = 32'hFFFF_FFFF;
    xfer(32'h1000_0010, 0, 2'd2, 0, '0, 0, "R4 outside window");
    xfer(BASE | (32'd25 << 14), 0, 2'd2, 0, '0, 0, "R4 no slot");
    xfer(BASE | (32'd6 << 14), 0, 2'd3, 0, '0, 0, "R11 data dword");
    xfer(BASE | (32'd19 << 14) | 32'h3FF8, 0, 2'd3, 1, '0, 0, "R4 fetch edge");
    xfer(BASE | (32'd8 << 14) | 32'h3FF8, 0, 2'd3, 1, '0, 0, "R8 slot cross");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule